// File: doc/BRIEF.md
# Supply Switchover and Power-Mode Controller

This block decides whether a metering chip runs from its line-derived supply or from a backup battery, and which of three power modes it is in. It watches two digital undervoltage flags from external comparators: one for the unregulated bulk input and one for the regulated supply. When either flag rises while the chip is on line power, it selects the battery and turns off the analog regulator, which powers the measurement converters and signal processing. The return to line power is held back until both flags have stayed clear for a software-programmed number of consecutive cycles. This gives the switch a digital timeout on top of the comparators' own hysteresis.

On battery the CPU keeps running until software asks for sleep. In sleep the digital regulator is off and only the always-on clock domain stays alive. Sleep ends when any enabled wake source fires: the midnight tick, a user alarm, a falling edge on the UART receive line, a temperature-change event, or either external interrupt. Sleep also ends when the line supply comes back, which is always enabled. Every wake lands in battery-run mode, never directly in line mode. A write-one-to-clear register records which sources caused the wake. Reset also serves as a wake: it always puts the block in battery-run mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 1 (battery run), `batt_sel`=1, `ana_reg_en`=0, `dig_reg_en`=1, `on_batt_stat`=1 and `wake_cause`=0. The `mode` encoding is 0 = line, 1 = battery run, 2 = battery sleep.
- R2: In line mode, if `bulk_low` or `vdd_low` is high at a clock edge, that edge moves the block to battery run. It sets `batt_sel`=1 and `ana_reg_en`=0. The analog regulator is never enabled while the battery is selected.
- R3: Battery run returns to line mode only at the edge that ends `qual_cycles` consecutive cycles in battery run with both flags low (a value of 0 counts as 1). Any flag pulse restarts the count. `ana_reg_en` rises with that transition.
- R4: A `sleep_req` sampled in battery run moves the block to sleep at that edge. In sleep, `dig_reg_en`=0 and the battery stays selected. `sleep_req` wins over a qualification completing in the same cycle.
- R5: A `sleep_req` in line mode is ignored: the mode stays line and `dig_reg_en` stays 1.
- R6: In sleep, a maskable source high at an edge moves the block to battery run at that edge, but only if its enable bit is set. The enable bits are `wake_en[0]` midnight, [1] alarm, [2] UART, [3] temperature, [4] INT0 and [5] INT1. A source whose enable bit is 0 has no effect.
- R7: In sleep, both flags low counts as an always-enabled line-restore wake. It goes to battery run, not line. Line mode then follows only after a full R3 qualification.
- R8: On a wake, the causing sources are OR-ed into `wake_cause`. Bit 0 is line restore, and bits 1 to 6 follow the `wake_en` order. Source activity outside sleep sets no bit.
- R9: Writing a 1 to a bit of `cause_clr` clears that bit of `wake_cause`. A wake that sets the same bit in the same cycle wins.
- R10: A UART wake is a high-to-low transition of `uart_rxd` after a two-flop synchronizer. A low driven before edge k wakes the block at edge k+2. A held low or a rising edge does not wake it.
- R11: `on_batt_stat` is 1 whenever the battery is selected (battery run or sleep) and 0 in line mode.
- R12: Asserting `rst_n` while in sleep returns the block to the R1 state, so reset acts as an unmaskable wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bulk_low | input | 1 | Bulk input below its threshold |
| vdd_low | input | 1 | Regulated supply below its threshold |
| sleep_req | input | 1 | Software request to enter sleep |
| rtc_midnight | input | 1 | Midnight tick from the clock domain |
| rtc_alarm | input | 1 | User alarm from the clock domain |
| uart_rxd | input | 1 | Asynchronous UART receive line |
| temp_evt | input | 1 | Temperature-change event |
| ext_int0 | input | 1 | External interrupt 0 |
| ext_int1 | input | 1 | External interrupt 1 |
| wake_en | input | 6 | Enable mask for maskable wake sources |
| cause_clr | input | 7 | Write-one-to-clear strobe for wake_cause |
| qual_cycles | input | CNT_W | Clean cycles required before returning to line |
| batt_sel | output | 1 | Battery switch select |
| ana_reg_en | output | 1 | Analog regulator enable |
| dig_reg_en | output | 1 | Digital regulator enable |
| on_batt_stat | output | 1 | Status: switch is on battery |
| mode | output | 2 | Current power mode |
| wake_cause | output | 7 | Latched wake sources |

## Verification
Two situations are hard to reach from the ports. The first is a qualification count cut short one cycle before it would finish. The stimulus reaches it by dropping both flags for fewer cycles than `qual_cycles`, inserting a single-cycle flag pulse, and then timing the restarted window exactly. The second is a UART wake, which needs a genuine high-to-low transition while the block is already asleep. The stimulus therefore keeps the receive line idle-high before each sleep entry and compares a one-cycle low pulse against a held low. A seeded random loop picks a source and an enable mask for each sleep episode, so both masked and unmasked wakes occur across all six sources.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [1:0] {
      PM_LINE   = 2'd0,
      PM_BATRUN = 2'd1,
      PM_SLEEP  = 2'd2
   } pmode_e;

   // maskable wake sources; line restore is the extra, always-enabled cause bit 0
   localparam int unsigned WAKE_SRC_N = 6;
   localparam int unsigned CAUSE_W    = WAKE_SRC_N + 1;
endpackage

// File: rtl/pwr_rx_fall.sv
module pwr_rx_fall #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd,
   output logic fall
);
   localparam int unsigned SH_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwr_rx_fall: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[SH_W-2:0], rxd};
   end

   assign fall = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/pwr_qual_timer.sv
module pwr_qual_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clean,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);
   localparam int unsigned EXT_W = CNT_W + 1;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("pwr_qual_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] seen_nxt;
   logic [EXT_W-1:0] lim_eff;

   assign seen_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign lim_eff  = (limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit};
   assign done     = run && clean && (seen_nxt >= lim_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (!run || !clean || done) cnt_q <= '0;
      else if (cnt_q != '1)            cnt_q <= seen_nxt[CNT_W-1:0];
   end
endmodule

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch #(
   parameter int unsigned SRC_N = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             line_ok,
   input  logic [SRC_N-1:0] src,
   input  logic [SRC_N-1:0] en,
   input  logic [SRC_N:0]   clr,
   output logic             wake,
   output logic [SRC_N:0]   cause
);
   logic [SRC_N:0] hits;
   logic [SRC_N:0] cause_q;

   assign hits = {src & en, line_ok};
   assign wake = armed && (|hits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_q & ~clr) | (armed ? hits : '0);
   end

   assign cause = cause_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bulk_low,
   input  logic                  vdd_low,
   input  logic                  sleep_req,
   input  logic                  rtc_midnight,
   input  logic                  rtc_alarm,
   input  logic                  uart_rxd,
   input  logic                  temp_evt,
   input  logic                  ext_int0,
   input  logic                  ext_int1,
   input  logic [WAKE_SRC_N-1:0] wake_en,
   input  logic [CAUSE_W-1:0]    cause_clr,
   input  logic [CNT_W-1:0]      qual_cycles,
   output logic                  batt_sel,
   output logic                  ana_reg_en,
   output logic                  dig_reg_en,
   output logic                  on_batt_stat,
   output logic [1:0]            mode,
   output logic [CAUSE_W-1:0]    wake_cause
);
   pmode_e state_q, state_d;

   logic supply_bad;
   logic rx_fall;
   logic qual_done;
   logic wake;
   logic [WAKE_SRC_N-1:0] src_vec;

   assign supply_bad = bulk_low | vdd_low;

   pwr_rx_fall #(.SYNC_STAGES(SYNC_STAGES)) u_rx_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .rxd   (uart_rxd),
      .fall  (rx_fall)
   );

   pwr_qual_timer #(.CNT_W(CNT_W)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == PM_BATRUN),
      .clean (!supply_bad),
      .limit (qual_cycles),
      .done  (qual_done)
   );

   // source order fixes the cause bit positions 1..6
   assign src_vec = {ext_int1, ext_int0, temp_evt, rx_fall, rtc_alarm, rtc_midnight};

   pwr_wake_latch #(.SRC_N(WAKE_SRC_N)) u_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (state_q == PM_SLEEP),
      .line_ok (!supply_bad),
      .src     (src_vec),
      .en      (wake_en),
      .clr     (cause_clr),
      .wake    (wake),
      .cause   (wake_cause)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_LINE:   if (supply_bad) state_d = PM_BATRUN;
         PM_BATRUN: begin
            if (sleep_req)      state_d = PM_SLEEP;
            else if (qual_done) state_d = PM_LINE;
         end
         PM_SLEEP:  if (wake) state_d = PM_BATRUN;
         default:   state_d = PM_BATRUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PM_BATRUN;
      else        state_q <= state_d;
   end

   assign batt_sel     = (state_q != PM_LINE);
   assign ana_reg_en   = (state_q == PM_LINE);
   assign dig_reg_en   = (state_q != PM_SLEEP);
   assign on_batt_stat = batt_sel;
   assign mode         = state_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bulk_low,
   input logic       vdd_low,
   input logic       sleep_req,
   input logic       batt_sel,
   input logic       ana_reg_en,
   input logic       dig_reg_en,
   input logic [1:0] mode,
   input logic [6:0] wake_cause
);
   // R2
   bat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && (bulk_low || vdd_low)) |=> (mode == 2'd1));

   // R2
   ana_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      batt_sel |-> !ana_reg_en);

   // R3
   dirty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && (bulk_low || vdd_low)) |=> (mode != 2'd0));

   // R4
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && sleep_req) |=> (mode == 2'd2 && !dig_reg_en));

   // R5
   line_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !bulk_low && !vdd_low) |=> (mode == 2'd0));

   // R7
   no_sleep_to_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |=> (mode != 2'd0));

   // R8
   cause_only_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd2) |=> ((wake_cause & ~$past(wake_cause)) == 7'd0));

   // R1
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bulk_low   (bulk_low),
   .vdd_low    (vdd_low),
   .sleep_req  (sleep_req),
   .batt_sel   (batt_sel),
   .ana_reg_en (ana_reg_en),
   .dig_reg_en (dig_reg_en),
   .mode       (mode),
   .wake_cause (wake_cause)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bulk_low = 1'b1, vdd_low = 1'b0, sleep_req = 1'b0;
   logic rtc_midnight = 1'b0, rtc_alarm = 1'b0, uart_rxd = 1'b1;
   logic temp_evt = 1'b0, ext_int0 = 1'b0, ext_int1 = 1'b0;
   logic [5:0] wake_en = 6'd0;
   logic [6:0] cause_clr = 7'd0;
   logic [CNT_W-1:0] qual_cycles = 16'd5;
   logic batt_sel, ana_reg_en, dig_reg_en, on_batt_stat;
   logic [1:0] mode;
   logic [6:0] wake_cause;

   int total = 0;
   int bad = 0;
   bit summary_done = 1'b0;

   always #10 clk = ~clk;

   pwr_mode_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .bulk_low(bulk_low), .vdd_low(vdd_low),
      .sleep_req(sleep_req), .rtc_midnight(rtc_midnight), .rtc_alarm(rtc_alarm),
      .uart_rxd(uart_rxd), .temp_evt(temp_evt), .ext_int0(ext_int0),
      .ext_int1(ext_int1), .wake_en(wake_en), .cause_clr(cause_clr),
      .qual_cycles(qual_cycles), .batt_sel(batt_sel), .ana_reg_en(ana_reg_en),
      .dig_reg_en(dig_reg_en), .on_batt_stat(on_batt_stat), .mode(mode),
      .wake_cause(wake_cause)
   );

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   // expected outputs from mode per R2/R4/R11
   function automatic logic [3:0] exp_ctl(logic [1:0] m);
      return {m != 2'd0, m == 2'd0, m != 2'd2, m != 2'd0};
   endfunction

   task automatic check_mode(string req, logic [1:0] m);
      check(req, {30'd0, mode}, {30'd0, m});
      check(req, {28'd0, batt_sel, ana_reg_en, dig_reg_en, on_batt_stat},
            {28'd0, exp_ctl(m)});
   endtask

   task automatic pulse_src(int idx);
      case (idx)
         0: rtc_midnight = 1'b1;
         1: rtc_alarm    = 1'b1;
         2: uart_rxd     = 1'b0;
         3: temp_evt     = 1'b1;
         4: ext_int0     = 1'b1;
         default: ext_int1 = 1'b1;
      endcase
      tick();
      rtc_midnight = 1'b0; rtc_alarm = 1'b0; uart_rxd = 1'b1;
      temp_evt = 1'b0; ext_int0 = 1'b0; ext_int1 = 1'b0;
   endtask

   task automatic go_sleep();
      sleep_req = 1'b1;
      tick();
      sleep_req = 1'b0;
   endtask

   task automatic clear_all();
      cause_clr = 7'h7F;
      tick();
      cause_clr = 7'h00;
   endtask

   initial begin
      #(20ns * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state (bulk_low held so qualification never starts)
      check_mode("R1", 2'd1);
      check("R1", {25'd0, wake_cause}, 32'd0);

      // R3 qualification with a glitch restart
      bulk_low = 1'b0;
      tick(4);
      check_mode("R3", 2'd1);
      vdd_low = 1'b1;
      tick();
      vdd_low = 1'b0;
      tick(4);
      check_mode("R3", 2'd1);
      tick();
      check_mode("R3", 2'd0);

      // R5 sleep request ignored on line
      sleep_req = 1'b1;
      tick();
      sleep_req = 1'b0;
      check_mode("R5", 2'd0);
      tick();
      check_mode("R5", 2'd0);

      // R2 regulated flag alone
      vdd_low = 1'b1;
      tick();
      check_mode("R2", 2'd1);
      vdd_low = 1'b0;
      tick(5);
      check_mode("R3", 2'd0);
      // R2 bulk flag alone
      bulk_low = 1'b1;
      tick();
      check_mode("R2", 2'd1);
      check("R11", {31'd0, on_batt_stat}, 32'd1);

      // R4 sleep entry
      go_sleep();
      check_mode("R4", 2'd2);

      // R6 masked source has no effect
      wake_en = 6'd0;
      pulse_src(4);
      tick();
      check_mode("R6", 2'd2);
      check("R6", {25'd0, wake_cause}, 32'd0);
      wake_en = 6'b010000;
      pulse_src(4);
      check_mode("R6", 2'd1);
      check("R8", {25'd0, wake_cause}, 32'h20);

      // R9 clear, then set-over-clear
      cause_clr = 7'h20;
      tick();
      cause_clr = 7'h00;
      check("R9", {25'd0, wake_cause}, 32'd0);
      wake_en = 6'h3F;
      go_sleep();
      rtc_alarm = 1'b1;
      cause_clr = 7'h04;
      tick();
      rtc_alarm = 1'b0;
      cause_clr = 7'h00;
      check("R9", {25'd0, wake_cause}, 32'h04);
      clear_all();

      // R10 UART falling edge, two-flop latency
      go_sleep();
      uart_rxd = 1'b0;
      tick(2);
      check_mode("R10", 2'd2);
      tick();
      check_mode("R10", 2'd1);
      check("R10", {25'd0, wake_cause}, 32'h08);
      clear_all();
      go_sleep();
      tick(4);
      check_mode("R10", 2'd2);
      uart_rxd = 1'b1;
      tick(4);
      check_mode("R10", 2'd2);
      check("R10", {25'd0, wake_cause}, 32'd0);
      pulse_src(5);
      check_mode("R6", 2'd1);
      clear_all();

      // R7 line restore wakes to battery run, then qualifies
      go_sleep();
      bulk_low = 1'b0;
      tick();
      check_mode("R7", 2'd1);
      check("R7", {25'd0, wake_cause}, 32'h01);
      tick(4);
      check_mode("R7", 2'd1);
      tick();
      check_mode("R7", 2'd0);
      clear_all();

      // R12 reset while sleeping
      bulk_low = 1'b1;
      tick();
      go_sleep();
      pulse_src(3);
      go_sleep();
      check_mode("R12", 2'd2);
      rst_n = 1'b0;
      #1;
      check_mode("R12", 2'd1);
      check("R12", {25'd0, wake_cause}, 32'd0);
      tick();
      rst_n = 1'b1;
      tick();

      // random wake episodes, R6 and R8
      for (int it = 0; it < 40; it++) begin
         int idx;
         logic [5:0] msk;
         idx = int'($urandom_range(0, 5));
         msk = 6'($urandom);
         wake_en = msk;
         go_sleep();
         pulse_src(idx);
         tick(2);
         if (msk[idx]) begin
            check_mode("R6", 2'd1);
            check("R8", {25'd0, wake_cause}, 32'(7'd1 << (idx + 1)));
         end else begin
            check_mode("R6", 2'd2);
            check("R8", {25'd0, wake_cause}, 32'd0);
            wake_en = 6'h3F;
            pulse_src(4);
         end
         clear_all();
      end

      if (!summary_done) begin
         summary_done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end
endmodule